// File: doc/BRIEF.md
# Dual-Byte Bidirectional Bus Transceiver Datapath

This block is the system-side logic of a bus transceiver built from independent lanes (two by default), each nine bits wide. Every lane links an A port and a B port and is controlled by two pins. The first is an active-low enable. The second is a direction pin: high carries A data onto B, and low carries B data onto A. The block registers the data each port drives, together with a tri-state enable for each port. A pad ring or tri-state buffer stage then drives the pins from those signals.

A lane does not drive anything straight after power-on. The power-on reset arms a hot-insertion guard in each lane. The guard keeps both ports of that lane undriven until the enable pin is seen going from inactive to active, and this holds even when the pin is already low as reset ends. Raising reset again at any time re-arms the guard, which models the power-down path.

The block also exposes each lane's internal active-high A-side and B-side enables for observation. A boundary-scan wrapper can take over the port enables through a per-lane override.

Top module: `xcvr_dual_byte`

## Requirements
- R1: The lanes are independent. Lane k uses bits [k*9+8 : k*9] of the data buses and bit k of every per-lane control or enable vector, and two lanes may run in opposite directions at the same time.
- R2: When a lane is unguarded, not overridden, its enable is low and its direction is 1, b_oe is 1 and a_oe is 0 after the next clock edge. b_out carries a_in as sampled at that edge, with no inversion.
- R3: When a lane is unguarded, not overridden, its enable is low and its direction is 0, a_oe is 1 and b_oe is 0 after the next clock edge. a_out carries b_in as sampled at that edge, with no inversion.
- R4: When a lane's enable is high and it is not overridden, a_oe and b_oe of that lane are both 0 after the next clock edge, whatever the direction.
- R5: While rst is high, every a_oe, b_oe, a_out and b_out is 0 and every lane becomes guarded. After rst falls, an enable held continuously low never releases the guard.
- R6: The guard of a lane is released by the first clock edge at which the enable is sampled low after having been sampled high at the previous edge. The port enable therefore rises at the edge after that one. Once released, the guard stays released until rst.
- R7: Raising rst again after normal operation re-guards every lane, and a fresh high-to-low enable transition is needed once more.
- R8: int_aoe equals not-guarded AND enable-low AND direction 0. int_boe equals not-guarded AND enable-low AND direction 1. The two are never high together in one lane.
- R9: While scan_ovr of a lane is 1, that lane's a_oe and b_oe take scan_aoe and scan_boe at the next clock edge, regardless of the guard, the enable or the direction.
- R10: Releasing the guard in one lane leaves a still-guarded lane with both port enables and both internal enables at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset; arms every guard |
| g_n | input | 2 | Per-lane active-low enable pin |
| dir | input | 2 | Per-lane direction: 1 = A to B, 0 = B to A |
| a_in | input | 18 | Values sensed on the A pins, lane k at bits k*9+8:k*9 |
| b_in | input | 18 | Values sensed on the B pins |
| scan_ovr | input | 2 | Per-lane scan override of the port enables |
| scan_aoe | input | 2 | A-side enable value forced while overridden |
| scan_boe | input | 2 | B-side enable value forced while overridden |
| a_out | output | 18 | Registered data to drive onto the A pins |
| b_out | output | 18 | Registered data to drive onto the B pins |
| a_oe | output | 2 | Registered per-lane A-port tri-state enable |
| b_oe | output | 2 | Registered per-lane B-port tri-state enable |
| int_aoe | output | 2 | Internal A-side enable, combinational, for scan observation |
| int_boe | output | 2 | Internal B-side enable, combinational, for scan observation |

## Verification
The data outputs and the port enables are one register away from the pins, so a change of data, direction, enable level or override shows at the ports after exactly one edge. The exception is a guarded lane. There the falling enable is first captured into the guard at one edge, int_aoe or int_boe rises just after that edge, and the port enable follows at the second edge. Inputs are changed between edges and each result is sampled a few nanoseconds after the edge at which it is due. The release case is checked at both edges, so a design one cycle early or late is caught, and a still-guarded lane and an enable held low through reset are checked over several edges.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned LANE_W_DEF  = 9;
  localparam int unsigned LANE_N_DEF  = 2;

  typedef struct packed {
    logic aoe;
    logic boe;
  } lane_en_t;
endpackage

// File: rtl/xcvr_hot_guard.sv
module xcvr_hot_guard (
  input  logic clk,
  input  logic rst,
  input  logic g_n,
  output logic guarded
);
  logic g_prev;
  logic guard_q;
  logic fall_seen;

  // High-to-low transition of the enable between two consecutive samples.
  assign fall_seen = g_prev & ~g_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      // Treat the pin as active during reset, so a pin that is held low
      // afterwards never looks like a fresh transition.
      g_prev  <= 1'b0;
      guard_q <= 1'b1;
    end else begin
      g_prev <= g_n;
      if (fall_seen) guard_q <= 1'b0;
    end
  end

  assign guarded = guard_q;

  assert_guard_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (guard_q && !(g_prev && !g_n)) |=> guard_q);

  assert_guard_release_R6: assert property (@(posedge clk) disable iff (rst)
    (g_prev && !g_n) |=> !guard_q);

  assert_guard_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !guard_q |=> !guard_q);
endmodule

// File: rtl/xcvr_oe_decode.sv
module xcvr_oe_decode
  import xcvr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     guarded,
  input  logic     g_n,
  input  logic     dir,
  input  logic     ovr,
  input  lane_en_t ovr_en,
  output lane_en_t int_en,
  output lane_en_t sel_en
);
  logic live;

  assign live       = ~guarded & ~g_n;
  assign int_en.aoe = live & ~dir;
  assign int_en.boe = live &  dir;
  assign sel_en     = ovr ? ovr_en : int_en;

  assert_one_side_R8: assert property (@(posedge clk) disable iff (rst)
    !(int_en.aoe && int_en.boe));

  assert_guard_mutes_R5: assert property (@(posedge clk) disable iff (rst)
    guarded |-> (!int_en.aoe && !int_en.boe));
endmodule

// File: rtl/xcvr_lane_regs.sv
module xcvr_lane_regs
  import xcvr_pkg::*;
#(
  parameter int unsigned W = LANE_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  lane_en_t     sel_en,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         a_oe,
  output logic         b_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      b_out <= '0;
      a_oe  <= 1'b0;
      b_oe  <= 1'b0;
    end else begin
      a_out <= b_in;
      b_out <= a_in;
      a_oe  <= sel_en.aoe;
      b_oe  <= sel_en.boe;
    end
  end
endmodule

// File: rtl/xcvr_dual_byte.sv
module xcvr_dual_byte
  import xcvr_pkg::*;
#(
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned LANE_N = LANE_N_DEF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANE_N-1:0]        g_n,
  input  logic [LANE_N-1:0]        dir,
  input  logic [LANE_N*LANE_W-1:0] a_in,
  input  logic [LANE_N*LANE_W-1:0] b_in,
  input  logic [LANE_N-1:0]        scan_ovr,
  input  logic [LANE_N-1:0]        scan_aoe,
  input  logic [LANE_N-1:0]        scan_boe,
  output logic [LANE_N*LANE_W-1:0] a_out,
  output logic [LANE_N*LANE_W-1:0] b_out,
  output logic [LANE_N-1:0]        a_oe,
  output logic [LANE_N-1:0]        b_oe,
  output logic [LANE_N-1:0]        int_aoe,
  output logic [LANE_N-1:0]        int_boe
);
  localparam int unsigned BUS_W = LANE_N * LANE_W;

  for (genvar k = 0; k < LANE_N; k++) begin : g_lane
    logic     guarded;
    lane_en_t int_en;
    lane_en_t sel_en;
    lane_en_t ovr_en;

    assign ovr_en.aoe = scan_aoe[k];
    assign ovr_en.boe = scan_boe[k];

    xcvr_hot_guard u_guard (
      .clk     (clk),
      .rst     (rst),
      .g_n     (g_n[k]),
      .guarded (guarded)
    );

    xcvr_oe_decode u_dec (
      .clk     (clk),
      .rst     (rst),
      .guarded (guarded),
      .g_n     (g_n[k]),
      .dir     (dir[k]),
      .ovr     (scan_ovr[k]),
      .ovr_en  (ovr_en),
      .int_en  (int_en),
      .sel_en  (sel_en)
    );

    xcvr_lane_regs #(.W(LANE_W)) u_regs (
      .clk    (clk),
      .rst    (rst),
      .sel_en (sel_en),
      .a_in   (a_in[k*LANE_W +: LANE_W]),
      .b_in   (b_in[k*LANE_W +: LANE_W]),
      .a_out  (a_out[k*LANE_W +: LANE_W]),
      .b_out  (b_out[k*LANE_W +: LANE_W]),
      .a_oe   (a_oe[k]),
      .b_oe   (b_oe[k])
    );

    assign int_aoe[k] = int_en.aoe;
    assign int_boe[k] = int_en.boe;

    assert_disabled_high_R4: assert property (@(posedge clk) disable iff (rst)
      (!scan_ovr[k] && g_n[k]) |=> (!a_oe[k] && !b_oe[k]));

    assert_ports_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
      !scan_ovr[k] |=> !(a_oe[k] && b_oe[k]));

    assert_data_a_to_b_R2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (b_out[k*LANE_W +: LANE_W] == $past(a_in[k*LANE_W +: LANE_W])));
  end

  assert_reset_quiet_R5: assert property (@(posedge clk)
    $past(rst) |-> (a_oe == '0 && b_oe == '0 && a_out == {BUS_W{1'b0}}));
endmodule

// File: tb/tb_xcvr_dual_byte.sv
module tb_xcvr_dual_byte;
  localparam int W = 9;
  localparam int N = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   g_n = '1;
  logic [N-1:0]   dir = '0;
  logic [N*W-1:0] a_in = '0;
  logic [N*W-1:0] b_in = '0;
  logic [N-1:0]   scan_ovr = '0;
  logic [N-1:0]   scan_aoe = '0;
  logic [N-1:0]   scan_boe = '0;
  logic [N*W-1:0] a_out, b_out;
  logic [N-1:0]   a_oe, b_oe, int_aoe, int_boe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xcvr_dual_byte dut (
    .clk(clk), .rst(rst), .g_n(g_n), .dir(dir), .a_in(a_in), .b_in(b_in),
    .scan_ovr(scan_ovr), .scan_aoe(scan_aoe), .scan_boe(scan_boe),
    .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
    .int_aoe(int_aoe), .int_boe(int_boe)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reset holds every output quiet.
  task automatic t_reset;
    rst = 1'b1; g_n = 2'b11; a_in = 18'h3ffff; b_in = 18'h3ffff;
    step(3);
    chk("R5", "a_oe in reset", 32'(a_oe), 0);
    chk("R5", "b_oe in reset", 32'(b_oe), 0);
    chk("R5", "a_out in reset", 32'(a_out), 0);
    chk("R5", "b_out in reset", 32'(b_out), 0);
  endtask

  // Lane 0 enable held low across reset release: stays guarded.
  task automatic t_held_low;
    g_n = 2'b00; dir = 2'b01;
    rst = 1'b0;
    step(4);
    chk("R5", "held low int_boe", 32'(int_boe), 0);
    chk("R5", "held low b_oe", 32'(b_oe), 0);
    chk("R5", "held low a_oe", 32'(a_oe), 0);
  endtask

  // Fresh falling edge on lane 0 only, direction A to B.
  task automatic t_release;
    g_n[0] = 1'b1;
    step(2);
    g_n[0] = 1'b0;
    step(1);
    chk("R6", "int_boe after capture edge", 32'(int_boe[0]), 1);
    chk("R6", "b_oe not yet", 32'(b_oe[0]), 0);
    step(1);
    chk("R6", "b_oe second edge", 32'(b_oe[0]), 1);
    chk("R2", "a_oe off for dir=1", 32'(a_oe[0]), 0);
    chk("R8", "int_aoe low while B drives", 32'(int_aoe[0]), 0);
    chk("R10", "lane1 a_oe guarded", 32'(a_oe[1]), 0);
    chk("R10", "lane1 b_oe guarded", 32'(b_oe[1]), 0);
    chk("R10", "lane1 int enables", 32'({int_aoe[1], int_boe[1]}), 0);
  endtask

  task automatic t_data_a_to_b;
    logic [W-1:0] pat [3] = '{9'h1a5, 9'h05a, 9'h100};
    for (int i = 0; i < 3; i++) begin
      a_in[W-1:0] = pat[i];
      step(1);
      chk("R2", "b_out lane0", 32'(b_out[W-1:0]), 32'(pat[i]));
    end
  endtask

  task automatic t_dir_b_to_a;
    dir[0] = 1'b0; b_in[W-1:0] = 9'h0c3;
    step(1);
    chk("R3", "a_oe lane0", 32'(a_oe[0]), 1);
    chk("R3", "b_oe lane0", 32'(b_oe[0]), 0);
    chk("R3", "a_out lane0", 32'(a_out[W-1:0]), 32'h0c3);
    chk("R8", "int_aoe lane0", 32'({int_aoe[0], int_boe[0]}), 2);
  endtask

  task automatic t_enable_high;
    for (int d = 0; d < 2; d++) begin
      dir[0] = d[0]; g_n[0] = 1'b1;
      step(1);
      chk("R4", "oe off with enable high", 32'({a_oe[0], b_oe[0]}), 0);
    end
    dir[0] = 1'b0; g_n[0] = 1'b0;
    step(1);
    chk("R6", "stays released, a_oe back", 32'(a_oe[0]), 1);
  endtask

  // Release lane 1 in the opposite direction from lane 0.
  task automatic t_both_lanes;
    g_n[1] = 1'b1; dir = 2'b10;
    step(1);
    g_n[1] = 1'b0;
    a_in[2*W-1:W] = 9'h155; b_in[W-1:0] = 9'h0aa;
    step(2);
    chk("R1", "lane oe pattern", 32'({a_oe, b_oe}), 32'b01_10);
    chk("R1", "lane1 b_out", 32'(b_out[2*W-1:W]), 32'h155);
    chk("R1", "lane0 a_out", 32'(a_out[W-1:0]), 32'h0aa);
  endtask

  task automatic t_rereset;
    rst = 1'b1;
    step(1);
    chk("R7", "oe cleared by reset", 32'({a_oe, b_oe}), 0);
    rst = 1'b0; g_n = 2'b00;
    step(3);
    chk("R7", "re-guarded", 32'({a_oe, b_oe, int_aoe, int_boe}), 0);
    // Override still drives a guarded lane.
    scan_ovr = 2'b10; scan_aoe = 2'b10; scan_boe = 2'b10;
    step(1);
    chk("R9", "override both on lane1", 32'({a_oe[1], b_oe[1]}), 3);
    chk("R9", "lane0 untouched", 32'({a_oe[0], b_oe[0]}), 0);
    scan_aoe = 2'b00;
    step(1);
    chk("R9", "override follows", 32'({a_oe[1], b_oe[1]}), 1);
    scan_ovr = 2'b00;
    step(1);
    chk("R9", "override off, guard holds", 32'({a_oe[1], b_oe[1]}), 0);
    g_n[0] = 1'b1;
    step(1);
    g_n[0] = 1'b0; dir[0] = 1'b1;
    step(2);
    chk("R7", "fresh edge re-enables", 32'(b_oe[0]), 1);
  endtask

  initial begin
    t_reset();
    t_held_low();
    t_release();
    t_data_a_to_b();
    t_dir_b_to_a();
    t_enable_high();
    t_both_lanes();
    t_rereset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule